// File: doc/BRIEF.md
# Dual Wiper Register Engine

This block executes commands for a pair of digitally set potentiometers. Each pot keeps a 6-bit volatile wiper counter and four 6-bit data registers that stand in for nonvolatile storage. A serial front end, outside this block, deframes the host traffic. It hands over one byte at a time, the chip-select level, and a step strobe for every serial clock pulse seen while an increment/decrement command is open. The block answers read commands with one result byte, drives a one-hot tap select for each pot's switch array, and reports a write-in-progress flag.

The wiper can be loaded in four ways:
- a direct serial write;
- a transfer from a data register, either for one pot or for both pots at once;
- single steps up or down;
- recall of register 0 whenever reset is applied.

Data-register writes are held as pending until chip select rises. They are then committed, unless the write-protect input is low or an earlier commit is still timing out. A committed write holds the busy flag high for a parameterised number of clocks.

Top module: `dwr_engine`

## Requirements
- R1: The data-register contents survive reset. Before any write, register r of pot p holds 16*p + 5*r + 3. While reset is applied, each wiper counter loads its own register 0, the busy flag clears and no read result is pending.
- R2: Each tap output has exactly one bit set, at the index equal to its pot's wiper value (0 selects bit 0, 63 selects bit 63).
- R3: An instruction byte is decoded as follows: opcode in bits 7..4, register index in bits 3..2, a reserved bit 1 that must be 0, and the pot in bit 0. The opcodes are: read wiper 1001, write wiper 1010, read register 1011, write register 1100, register-to-wiper 1101, wiper-to-register 1110, global register-to-wiper 0001, global wiper-to-register 1000, step 0010, read status 0101. Any other opcode, or bit 1 set, is ignored together with the rest of the frame.
- R4: Register-to-wiper loads the selected pot's wiper from the indexed register at the clock edge that takes the instruction byte, and leaves the other pot unchanged.
- R5: Global register-to-wiper loads both wipers, each from its own register at the same index.
- R6: Wiper-to-register, single or global, captures the wiper value or values at the instruction byte and stores them into the indexed register when chip select rises.
- R7: Read wiper and read register present `rd_valid` for one cycle after the edge that takes the instruction byte. `rd_data` carries the 6-bit value with bits 7..6 zero, and the third byte of the frame is a don't-care.
- R8: Write wiper loads the low six bits of the third byte into the selected wiper at the edge that takes that byte.
- R9: A register write changes storage only at a chip-select rise that follows a complete data byte. A frame closed before its data byte writes nothing.
- R10: A commit raises `wip` for exactly WRITE_CYCLES clocks. Read status returns `wip` in bit 0, with bits 7..1 zero.
- R11: A pending write is discarded, and `wip` is not raised, if `wp_n` is low or `wip` is already high at the chip-select rise.
- R12: While a step command is open, each step strobe moves the selected wiper one count up (`step_up`=1) or down (`step_up`=0). It saturates at 63 and at 0, and strobes received once chip select is high have no effect.
- R13: Bytes that arrive after a command has completed are ignored until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; triggers register-0 recall |
| cs_n | input | 1 | Chip-select level, low while a frame is open |
| wp_n | input | 1 | Write-protect, low blocks register commits |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | Received byte |
| step_valid | input | 1 | One serial clock pulse during a step command |
| step_up | input | 1 | Direction of the step: 1 up, 0 down |
| rd_valid | output | 1 | Result byte valid |
| rd_data | output | 8 | Result byte |
| wip | output | 1 | Nonvolatile write in progress |
| wiper0 | output | 6 | Pot 0 wiper counter |
| wiper1 | output | 6 | Pot 1 wiper counter |
| tap0 | output | 64 | Pot 0 one-hot tap select |
| tap1 | output | 64 | Pot 1 one-hot tap select |

## Verification
The hardest state to reach is a second write whose commit falls inside the busy window of the first. The stimulus commits one register write and, while the flag is still high, opens a new frame with a different write and closes it. It then reads the status inside the window, waits for the flag to drop, and reads both registers back to show that only the first write took effect. Recall of a value the host itself stored is also reached only indirectly: a wiper-to-register transfer into register 0 is followed by a reset pulse, and the wiper output is then compared with the stored value.

// File: rtl/dwr_pkg.sv
`timescale 1ns/1ps
package dwr_pkg;
    localparam int WIPER_W   = 6;
    localparam int TAP_N     = 1 << WIPER_W;
    localparam int POT_N     = 2;
    localparam int REG_N     = 4;
    localparam int REG_IW    = $clog2(REG_N);
    localparam int IMG_W     = POT_N * REG_N * WIPER_W;

    typedef logic [WIPER_W-1:0] wiper_t;

    typedef enum logic [3:0] {
        OP_GX_DR2W = 4'b0001,
        OP_STEP    = 4'b0010,
        OP_RDSTAT  = 4'b0101,
        OP_GX_W2DR = 4'b1000,
        OP_RD_W    = 4'b1001,
        OP_WR_W    = 4'b1010,
        OP_RD_DR   = 4'b1011,
        OP_WR_DR   = 4'b1100,
        OP_DR2W    = 4'b1101,
        OP_W2DR    = 4'b1110
    } opcode_e;

    typedef enum logic [2:0] {
        ST_OP, ST_DATA_W, ST_DATA_DR, ST_STEP, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              known;
        opcode_e           op;
        logic [REG_IW-1:0] idx;
        logic              pot;
    } instr_t;

    typedef struct packed {
        logic                      valid;
        logic [POT_N-1:0]          mask;
        logic [REG_IW-1:0]         idx;
        logic [POT_N*WIPER_W-1:0]  data;
    } nv_req_t;

    function automatic wiper_t factory_value(input int p, input int r);
        return wiper_t'(16 * p + 5 * r + 3);
    endfunction

    function automatic logic [IMG_W-1:0] factory_image();
        logic [IMG_W-1:0] img;
        img = '0;
        for (int p = 0; p < POT_N; p++)
            for (int r = 0; r < REG_N; r++)
                img[(p*REG_N + r)*WIPER_W +: WIPER_W] = factory_value(p, r);
        return img;
    endfunction

    function automatic wiper_t dr_pick(input logic [IMG_W-1:0] img, input int p, input int r);
        return img[(p*REG_N + r)*WIPER_W +: WIPER_W];
    endfunction
endpackage

// File: rtl/dwr_decode.sv
`timescale 1ns/1ps
module dwr_decode
    import dwr_pkg::*;
(
    input  logic [7:0] instr_byte,
    output instr_t     dec
);
    always_comb begin
        dec.op  = opcode_e'(instr_byte[7:4]);
        dec.idx = instr_byte[3:2];
        dec.pot = instr_byte[0];
        unique case (instr_byte[7:4])
            OP_GX_DR2W, OP_STEP, OP_RDSTAT, OP_GX_W2DR, OP_RD_W,
            OP_WR_W, OP_RD_DR, OP_WR_DR, OP_DR2W, OP_W2DR:
                dec.known = ~instr_byte[1];
            default:
                dec.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/dwr_nvstore.sv
`timescale 1ns/1ps
module dwr_nvstore
    import dwr_pkg::*;
#(
    parameter int WRITE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              commit,
    input  nv_req_t           req,
    output logic              busy,
    output logic [IMG_W-1:0]  image
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] remain;
    logic             accept;
    logic [IMG_W-1:0] store = factory_image();

    assign accept = commit && req.valid && wp_n && !busy;
    assign busy   = (remain != '0);
    assign image  = store;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (accept)
            remain <= CNT_W'(WRITE_CYCLES);
        else if (busy)
            remain <= remain - 1'b1;
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < POT_N; p++)
            if (accept && req.mask[p])
                store[(p*REG_N + int'(req.idx))*WIPER_W +: WIPER_W]
                    <= req.data[p*WIPER_W +: WIPER_W];
    end

    assert_commit_raises_wip_R10: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    assert_wip_ends_R10: assert property (@(posedge clk) disable iff (rst)
        (remain == CNT_W'(1) && !accept) |=> !busy);
    assert_store_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(store));
    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        (commit && busy) |=> $stable(store));
    assert_protect_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        (commit && !wp_n) |=> $stable(store));
endmodule

// File: rtl/dwr_wiper.sv
`timescale 1ns/1ps
module dwr_wiper
    import dwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wiper_t           recall_val,
    input  logic             ld_en,
    input  wiper_t           ld_val,
    input  logic             step_en,
    input  logic             step_up,
    output wiper_t           wiper,
    output logic [TAP_N-1:0] tap
);
    localparam wiper_t TOP = wiper_t'(TAP_N - 1);

    always_ff @(posedge clk) begin
        if (rst)
            wiper <= recall_val;
        else if (ld_en)
            wiper <= ld_val;
        else if (step_en) begin
            if (step_up && wiper != TOP)
                wiper <= wiper + 1'b1;
            else if (!step_up && wiper != '0)
                wiper <= wiper - 1'b1;
        end
    end

    assign tap = TAP_N'(1) << wiper;

    assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(tap) == 1);
    assert_step_up_R12: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_up && !ld_en && wiper != TOP) |=> wiper == $past(wiper) + 1'b1);
    assert_step_down_R12: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_up && !ld_en && wiper != '0) |=> wiper == $past(wiper) - 1'b1);
    assert_ceiling_R12: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_up && !ld_en && wiper == TOP) |=> wiper == TOP);
    assert_floor_R12: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_up && !ld_en && wiper == '0) |=> wiper == '0);
endmodule

// File: rtl/dwr_engine.sv
`timescale 1ns/1ps
module dwr_engine
    import dwr_pkg::*;
#(
    parameter int WRITE_CYCLES = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        wp_n,
    input  logic        byte_valid,
    input  logic [7:0]  byte_data,
    input  logic        step_valid,
    input  logic        step_up,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        wip,
    output logic [5:0]  wiper0,
    output logic [5:0]  wiper1,
    output logic [63:0] tap0,
    output logic [63:0] tap1
);
    seq_state_e               state;
    instr_t                   dec;
    nv_req_t                  pend;
    logic                     cur_pot;
    logic                     cs_q;
    logic                     cs_rise;
    logic                     take_op;
    logic                     take_wdat;
    logic [IMG_W-1:0]         image;
    logic [POT_N*WIPER_W-1:0] wiper_flat;
    logic [POT_N*TAP_N-1:0]   tap_flat;
    logic [POT_N-1:0]         ld_en;
    logic [POT_N-1:0]         step_en;
    wiper_t                   ld_val   [POT_N];
    wiper_t                   cur_wipe;

    dwr_decode u_dec (.instr_byte(byte_data), .dec(dec));

    assign cs_rise   = cs_n && !cs_q;
    assign take_op   = byte_valid && !cs_n && state == ST_OP && dec.known;
    assign take_wdat = byte_valid && !cs_n && state == ST_DATA_W;
    assign cur_wipe  = wiper_flat[int'(dec.pot)*WIPER_W +: WIPER_W];

    always_comb begin
        for (int p = 0; p < POT_N; p++) begin
            ld_en[p] = (take_op && ((dec.op == OP_DR2W && int'(dec.pot) == p) ||
                                    dec.op == OP_GX_DR2W)) ||
                       (take_wdat && int'(cur_pot) == p);
            ld_val[p] = take_op ? dr_pick(image, p, int'(dec.idx)) : byte_data[WIPER_W-1:0];
            step_en[p] = step_valid && !cs_n && state == ST_STEP && int'(cur_pot) == p;
        end
    end

    dwr_nvstore #(.WRITE_CYCLES(WRITE_CYCLES)) u_nv (
        .clk(clk), .rst(rst), .wp_n(wp_n), .commit(cs_rise),
        .req(pend), .busy(wip), .image(image)
    );

    for (genvar g = 0; g < POT_N; g++) begin : g_pot
        dwr_wiper u_wiper (
            .clk(clk), .rst(rst),
            .recall_val(dr_pick(image, g, 0)),
            .ld_en(ld_en[g]), .ld_val(ld_val[g]),
            .step_en(step_en[g]), .step_up(step_up),
            .wiper(wiper_flat[g*WIPER_W +: WIPER_W]),
            .tap(tap_flat[g*TAP_N +: TAP_N])
        );
    end

    assign wiper0 = wiper_flat[0 +: WIPER_W];
    assign wiper1 = wiper_flat[WIPER_W +: WIPER_W];
    assign tap0   = tap_flat[0 +: TAP_N];
    assign tap1   = tap_flat[TAP_N +: TAP_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OP;
            pend     <= '0;
            cur_pot  <= 1'b0;
            cs_q     <= 1'b1;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            cs_q     <= cs_n;
            rd_valid <= 1'b0;
            if (cs_n) begin
                state      <= ST_OP;
                pend.valid <= 1'b0;
            end else begin
                unique case (state)
                    ST_OP: if (byte_valid) begin
                        cur_pot  <= dec.pot;
                        pend.idx <= dec.idx;
                        state    <= ST_DONE;
                        if (dec.known) begin
                            unique case (dec.op)
                                OP_RD_W: begin
                                    rd_valid <= 1'b1;
                                    rd_data  <= {2'b00, cur_wipe};
                                end
                                OP_RD_DR: begin
                                    rd_valid <= 1'b1;
                                    rd_data  <= {2'b00, dr_pick(image, int'(dec.pot), int'(dec.idx))};
                                end
                                OP_RDSTAT: begin
                                    rd_valid <= 1'b1;
                                    rd_data  <= {7'b0, wip};
                                end
                                OP_WR_W:  state <= ST_DATA_W;
                                OP_WR_DR: state <= ST_DATA_DR;
                                OP_STEP:  state <= ST_STEP;
                                OP_W2DR, OP_GX_W2DR: begin
                                    pend.valid <= 1'b1;
                                    pend.data  <= wiper_flat;
                                    pend.mask  <= (dec.op == OP_GX_W2DR) ? '1
                                                  : POT_N'(1) << dec.pot;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_DATA_W: if (byte_valid) state <= ST_DONE;
                    ST_DATA_DR: if (byte_valid) begin
                        pend.valid <= 1'b1;
                        pend.mask  <= POT_N'(1) << cur_pot;
                        pend.data  <= {POT_N{byte_data[WIPER_W-1:0]}};
                        state      <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_read_follows_byte_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(byte_valid));
    assert_read_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_data[7:6] == 2'b00);
    assert_closed_no_step_R12: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !byte_valid) |=> $stable(wiper_flat));
    assert_done_ignores_R13: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !cs_n) |=> ($stable(wiper_flat) && !rd_valid));
endmodule

// File: tb/dwr_engine_test.sv
`timescale 1ns/1ps
module dwr_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wp_n = 1'b1;
    logic        byte_valid = 1'b0, step_valid = 1'b0, step_up = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        rd_valid, wip;
    logic [7:0]  rd_data;
    logic [5:0]  wiper0, wiper1;
    logic [63:0] tap0, tap1;

    int checks = 0, fails = 0;
    int     exp_val[$];
    string  exp_tag[$];
    bit     ended = 0;

    always #2 clk = ~clk;

    dwr_engine uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .step_valid(step_valid), .step_up(step_up),
        .rd_valid(rd_valid), .rd_data(rd_data), .wip(wip),
        .wiper0(wiper0), .wiper1(wiper1), .tap0(tap0), .tap1(tap1)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: every result byte must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_val.size() == 0)
                chk("R13 unexpected result byte", int'(rd_data), -1);
            else
                chk(exp_tag.pop_front(), int'(rd_data), exp_val.pop_front());
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic csl();
        cs_n = 1'b0; @(negedge clk);
    endtask
    task automatic csh();
        cs_n = 1'b1; @(negedge clk);
    endtask
    task automatic sb(input logic [7:0] b);
        byte_valid = 1'b1; byte_data = b; @(negedge clk);
        byte_valid = 1'b0;
    endtask
    task automatic stp(input logic up);
        step_valid = 1'b1; step_up = up; @(negedge clk);
        step_valid = 1'b0;
    endtask
    task automatic rd(input logic [7:0] cmd, input string tag, input int exp);
        exp_val.push_back(exp); exp_tag.push_back(tag);
        sb(cmd); sb(8'h00);
    endtask
    task automatic rdf(input logic [7:0] cmd, input string tag, input int exp);
        csl(); rd(cmd, tag, exp); csh();
    endtask
    task automatic wait_idle();
        while (wip) @(negedge clk);
    endtask

    initial begin
        idle(3); rst = 1'b0; idle(1);
        // R1 reset recall and R2 tap decode
        chk("R1 wiper0 recall", wiper0, 3);
        chk("R1 wiper1 recall", wiper1, 19);
        chk("R1 wip after reset", wip, 0);
        chk("R2 tap0 one-hot", int'(tap0 == 64'd1 << 3), 1);
        // R7 read register
        rdf(8'hB9, "R7 read pot1 reg2", 29);
        // R8 write wiper, upper bits dropped
        csl(); sb(8'hA0); sb(8'hFE);
        chk("R8 write wiper0", wiper0, 62);
        csh();
        // R12 step up with ceiling, closed frame ignored
        csl(); sb(8'h20);
        stp(1'b1); chk("R12 step up", wiper0, 63);
        stp(1'b1); chk("R12 ceiling", wiper0, 63);
        chk("R2 tap0 top", int'(tap0 == 64'd1 << 63), 1);
        csh();
        stp(1'b0); chk("R12 strobe after close", wiper0, 63);
        // R12 step down with floor
        csl(); sb(8'hA1); sb(8'h01); csh();
        csl(); sb(8'h21);
        stp(1'b0); stp(1'b0);
        chk("R12 floor", wiper1, 0);
        chk("R2 tap1 bottom", int'(tap1 == 64'd1), 1);
        stp(1'b1); chk("R12 step up from floor", wiper1, 1);
        csh();
        // R4 single transfer
        csl(); sb(8'hDD);
        chk("R4 wiper1 from reg3", wiper1, 34);
        chk("R4 wiper0 untouched", wiper0, 63);
        csh();
        // R5 global transfer index 1
        csl(); sb(8'h14);
        chk("R5 wiper0 from reg1", wiper0, 8);
        chk("R5 wiper1 from reg1", wiper1, 24);
        csh();
        // R3 unknown opcode and reserved bit
        csl(); sb(8'h3D); sb(8'hD0); csh();
        chk("R3 unknown opcode ignored", wiper0, 8);
        csl(); sb(8'hD2); csh();
        chk("R3 reserved bit set ignored", wiper0, 8);
        // R13 extra byte after a completed read
        csl(); rd(8'h90, "R7 read wiper0", 8); sb(8'hD0);
        chk("R13 trailing byte ignored", wiper0, 8);
        csh();
        rdf(8'h91, "R7 read wiper1", 24);
        // R9 / R10 register write and busy time
        csl(); sb(8'hC8); sb(8'h2A);
        chk("R9 no commit before close", wip, 0);
        idle(2);
        chk("R9 still no commit", wip, 0);
        csh();
        chk("R10 wip raised", wip, 1);
        begin
            int n = 0;
            while (wip) begin n++; @(negedge clk); end
            chk("R10 busy length", n, 40);
        end
        rdf(8'hB8, "R9 readback pot0 reg2", 42);
        // R11 write while busy
        csl(); sb(8'hCC); sb(8'h05); csh();
        csl(); sb(8'hCD); sb(8'h11); csh();
        rdf(8'h50, "R10 status busy", 1);
        wait_idle();
        rdf(8'h50, "R10 status idle", 0);
        rdf(8'hBC, "R11 first write kept", 5);
        rdf(8'hBD, "R11 busy write rejected", 34);
        // R6 wiper to register 0, then R1 recall of it
        csl(); sb(8'hE1); csh(); wait_idle();
        rdf(8'hB1, "R6 pot1 reg0", 24);
        rst = 1'b1; idle(1); rst = 1'b0; idle(1);
        chk("R1 wiper0 after second reset", wiper0, 3);
        chk("R1 wiper1 recalls stored", wiper1, 24);
        // R6 global wiper to register 2
        csl(); sb(8'h88); csh(); wait_idle();
        rdf(8'hB8, "R6 global pot0 reg2", 3);
        rdf(8'hB9, "R6 global pot1 reg2", 24);
        // R11 write protect
        wp_n = 1'b0;
        csl(); sb(8'hC5); sb(8'h07); csh();
        chk("R11 protected no wip", wip, 0);
        wp_n = 1'b1;
        rdf(8'hB5, "R11 protected unchanged", 24);
        // R9 frame closed before data byte
        csl(); sb(8'hC4); csh();
        chk("R9 short frame no wip", wip, 0);
        rdf(8'hB4, "R9 short frame unchanged", 8);
        idle(3);
        chk("R7 all results seen", exp_val.size(), 0);
        finish_up();
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end
endmodule